// File: doc/BRIEF.md
# D-Channel Line Frame Multiplexer

This block builds the per-frame serial bit sequence of a two-wire digital line from two bearer bytes, an 8-bit signalling byte and one housekeeping bit, and splits a received frame of the same shape back into those fields. One line bit is moved per clock. The frame shape depends on three settings. The line rate selects the low rate (one bearer byte, one signalling bit per frame) or the high rate (two bearer bytes, two signalling bits per frame). The D-in-B option sends the whole signalling byte in the first bearer slot, which gives a 64 kbit/s signalling link. The modem option strips the signalling and housekeeping bits from the frame.

The three settings and all transmit data are sampled together on the clock edge that ends a frame, so a frame is never built from a mix of old and new values. A frame-start strobe marks the first bit of every frame. The receive side uses the frame counter and settings of the frame in flight. It publishes the rebuilt fields with a one-cycle done pulse after the last bit of each frame. Signalling bit positions that the frame did not carry read back as 1.

Top module: `dchan_line_mux`

## Requirements
- R1: While `rst_n` is low, and after its release until the first rising clock edge, `line_tx` is 1, `frame_start` is 0 and `rx_done` is 0. The first frame begins on the first rising edge with `rst_n` high.
- R2: At the low rate (`hi_rate`=0) in normal mode, a frame is 10 bits long: `tx_b1` bit 7 down to bit 0, then `tx_d` bit 0, then `tx_hk`.
- R3: At the high rate (`hi_rate`=1) in normal mode, a frame is 19 bits long: `tx_b1` bits 7..0, then `tx_b2` bits 7..0, then `tx_d` bit 1, then `tx_d` bit 0, then `tx_hk`.
- R4: With `d_in_b`=1 and `modem_mode`=0, the first bearer slot carries `tx_d` bits 7..0 instead of `tx_b1`. The dedicated signalling bit times carry 1.
- R5: With `modem_mode`=1, a frame holds only the bearer slots: 8 bits at the low rate and 16 at the high rate. No signalling or housekeeping bits are sent, and `d_in_b` has no effect.
- R6: `frame_start` is 1 during the first bit of each frame and 0 during every other bit.
- R7: The settings and the transmit data used for a frame are those present at the rising edge that ends the previous frame. A change in the middle of a frame does not alter the frame in flight.
- R8: On the rising edge that ends a frame, `rx_done` goes to 1 for one cycle. At the same time `rx_b1`, `rx_b2`, `rx_d` and `rx_hk` take the `line_rx` bits of that frame, read in the same layout as transmit.
- R9: Fields that a frame did not carry read back as all ones. This covers `rx_b2` at the low rate, `rx_d` bits above the carried signalling bits, `rx_b1` in D-in-B mode, and `rx_d` and `rx_hk` in modem mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_rate | input | 1 | 1 selects the high rate, 0 the low rate |
| d_in_b | input | 1 | 1 sends the signalling byte in the first bearer slot |
| modem_mode | input | 1 | 1 drops the signalling and housekeeping bits from the frame |
| tx_b1 | input | 8 | First bearer byte to send |
| tx_b2 | input | 8 | Second bearer byte to send (high rate only) |
| tx_d | input | 8 | Signalling byte to send |
| tx_hk | input | 1 | Housekeeping bit to send |
| line_tx | output | 1 | Serial line bit out |
| frame_start | output | 1 | High during the first bit of each frame |
| line_rx | input | 1 | Serial line bit in, same framing as transmit |
| rx_b1 | output | 8 | Received first bearer byte |
| rx_b2 | output | 8 | Received second bearer byte |
| rx_d | output | 8 | Rebuilt signalling byte |
| rx_hk | output | 1 | Received housekeeping bit |
| rx_done | output | 1 | One-cycle pulse when the receive fields update |

## Verification
A transmit bit is due in the same cycle that the frame counter points at it. Its contents come from the inputs seen at the edge that closed the previous frame. The reference model therefore rebuilds its expected bit queue at exactly that edge and compares `line_tx` and `frame_start` on the falling edge of every cycle. Receive fields and `rx_done` are due one cycle after the edge that takes in the last bit of a frame. The model computes them at that edge and checks them on the following falling edge. `rx_done` must be 0 on all other falling edges. A closing phase changes every input on every cycle to show that only frame-boundary values are used.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

   typedef enum logic [1:0] {
      SLOT_B1 = 2'd0,
      SLOT_B2 = 2'd1,
      SLOT_D  = 2'd2,
      SLOT_HK = 2'd3
   } slot_e;

   typedef struct packed {
      logic hi_rate;
      logic d_in_b;
      logic modem;
   } lcfg_t;

endpackage

// File: rtl/dlm_frame_timer.sv
module dlm_frame_timer
   import dlm_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int LO_DBITS = 1,
   parameter int HI_DBITS = 2,
   parameter int CNT_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lcfg_t            cfg_in,
   output logic [CNT_W-1:0] cnt,
   output lcfg_t            cfg_q,
   output logic             primed,
   output logic             last,
   output logic             load
);

   localparam logic [CNT_W-1:0] LEN_LO_N = CNT_W'(BYTE_W + LO_DBITS + 1);
   localparam logic [CNT_W-1:0] LEN_HI_N = CNT_W'(2*BYTE_W + HI_DBITS + 1);
   localparam logic [CNT_W-1:0] LEN_LO_M = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LEN_HI_M = CNT_W'(2*BYTE_W);

   if ((2*BYTE_W + HI_DBITS + 1) >= (1 << CNT_W)) begin : g_bad_cnt
      $error("dlm_frame_timer: CNT_W too narrow for the longest frame");
   end

   logic [CNT_W-1:0] len_q;

   always_comb begin
      unique case ({cfg_q.modem, cfg_q.hi_rate})
         2'b00:   len_q = LEN_LO_N;
         2'b01:   len_q = LEN_HI_N;
         2'b10:   len_q = LEN_LO_M;
         default: len_q = LEN_HI_M;
      endcase
   end

   assign last = primed && (cnt == len_q - CNT_W'(1));
   assign load = !primed || last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         cfg_q  <= '0;
         primed <= 1'b0;
      end else begin
         primed <= 1'b1;
         if (load) begin
            cfg_q <= cfg_in;
            cnt   <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (cnt < len_q));

   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !last) |=> $stable(cfg_q));

   assert_prime_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      primed |=> primed);

endmodule

// File: rtl/dlm_slot_decode.sv
module dlm_slot_decode
   import dlm_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int LO_DBITS = 1,
   parameter int HI_DBITS = 2,
   parameter int CNT_W    = 5,
   parameter int IDX_W    = 3
) (
   input  logic [CNT_W-1:0] cnt,
   input  lcfg_t            cfg,
   output slot_e            slot,
   output logic [IDX_W-1:0] idx
);

   localparam logic [CNT_W-1:0] P_B2   = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] P_HI_D = CNT_W'(2*BYTE_W);
   localparam logic [CNT_W-1:0] ND_LO  = CNT_W'(LO_DBITS);
   localparam logic [CNT_W-1:0] ND_HI  = CNT_W'(HI_DBITS);

   logic [CNT_W-1:0] d_end;
   logic [CNT_W-1:0] rel;

   always_comb begin
      d_end = cfg.hi_rate ? (P_HI_D + ND_HI) : (P_B2 + ND_LO);
      slot  = SLOT_HK;
      rel   = '0;
      if (cnt < P_B2) begin
         slot = SLOT_B1;
         rel  = P_B2 - CNT_W'(1) - cnt;
      end else if (cfg.hi_rate && (cnt < P_HI_D)) begin
         slot = SLOT_B2;
         rel  = P_HI_D - CNT_W'(1) - cnt;
      end else if (cnt < d_end) begin
         slot = SLOT_D;
         rel  = d_end - CNT_W'(1) - cnt;
      end
      idx = rel[IDX_W-1:0];
   end

endmodule

// File: rtl/dlm_tx_mux.sv
module dlm_tx_mux
   import dlm_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              primed,
   input  lcfg_t             cfg,
   input  slot_e             slot,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] b1_in,
   input  logic [BYTE_W-1:0] b2_in,
   input  logic [BYTE_W-1:0] d_in,
   input  logic              hk_in,
   output logic              line_bit
);

   logic [BYTE_W-1:0] b1_q, b2_q, d_q;
   logic              hk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b1_q <= '1;
         b2_q <= '1;
         d_q  <= '1;
         hk_q <= 1'b1;
      end else if (load) begin
         b1_q <= b1_in;
         b2_q <= b2_in;
         d_q  <= d_in;
         hk_q <= hk_in;
      end
   end

   logic dinb_live;
   assign dinb_live = cfg.d_in_b && !cfg.modem;

   always_comb begin
      if (!primed) begin
         line_bit = 1'b1;
      end else begin
         unique case (slot)
            SLOT_B1: line_bit = dinb_live ? d_q[idx] : b1_q[idx];
            SLOT_B2: line_bit = b2_q[idx];
            SLOT_D:  line_bit = cfg.d_in_b ? 1'b1 : d_q[idx];
            default: line_bit = hk_q;
         endcase
      end
   end

   assert_idle_unprimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> line_bit);

   assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(d_q) && $stable(b1_q) && $stable(hk_q));

endmodule

// File: rtl/dlm_rx_demux.sv
module dlm_rx_demux
   import dlm_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int LO_DBITS = 1,
   parameter int HI_DBITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              primed,
   input  logic              last,
   input  lcfg_t             cfg,
   input  slot_e             slot,
   input  logic              line_bit,
   output logic [BYTE_W-1:0] rx_b1,
   output logic [BYTE_W-1:0] rx_b2,
   output logic [BYTE_W-1:0] rx_d,
   output logic              rx_hk,
   output logic              rx_done
);

   logic [BYTE_W-1:0]   acc_b1, acc_b2, b1_n, b2_n;
   logic [HI_DBITS-1:0] acc_d, d_n;
   logic                acc_hk, hk_n;
   logic [BYTE_W-1:0]   d_lo, d_hi;

   always_comb begin
      b1_n = acc_b1;
      b2_n = acc_b2;
      hk_n = acc_hk;
      if (primed && slot == SLOT_B1) b1_n = {acc_b1[BYTE_W-2:0], line_bit};
      if (primed && slot == SLOT_B2) b2_n = {acc_b2[BYTE_W-2:0], line_bit};
      if (primed && slot == SLOT_HK) hk_n = line_bit;
   end

   if (HI_DBITS == 1) begin : g_d_single
      assign d_n = (primed && slot == SLOT_D) ? line_bit : acc_d;
   end else begin : g_d_shift
      assign d_n = (primed && slot == SLOT_D) ? {acc_d[HI_DBITS-2:0], line_bit} : acc_d;
   end

   for (genvar i = 0; i < BYTE_W; i++) begin : g_dpack
      if (i < LO_DBITS) begin : g_lo_use
         assign d_lo[i] = d_n[i];
      end else begin : g_lo_fill
         assign d_lo[i] = 1'b1;
      end
      if (i < HI_DBITS) begin : g_hi_use
         assign d_hi[i] = d_n[i];
      end else begin : g_hi_fill
         assign d_hi[i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_b1  <= '1;
         acc_b2  <= '1;
         acc_d   <= '1;
         acc_hk  <= 1'b1;
         rx_b1   <= '1;
         rx_b2   <= '1;
         rx_d    <= '1;
         rx_hk   <= 1'b1;
         rx_done <= 1'b0;
      end else begin
         acc_b1  <= b1_n;
         acc_b2  <= b2_n;
         acc_d   <= d_n;
         acc_hk  <= hk_n;
         rx_done <= last;
         if (last) begin
            rx_b1 <= (cfg.d_in_b && !cfg.modem) ? '1 : b1_n;
            rx_b2 <= cfg.hi_rate ? b2_n : '1;
            if (cfg.modem)       rx_d <= '1;
            else if (cfg.d_in_b) rx_d <= b1_n;
            else                 rx_d <= cfg.hi_rate ? d_hi : d_lo;
            rx_hk <= cfg.modem ? 1'b1 : hk_n;
         end
      end
   end

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   assert_b2_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !$past(cfg.hi_rate)) |-> (rx_b2 == '1));

   assert_modem_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && $past(cfg.modem)) |-> (rx_d == '1) && rx_hk);

endmodule

// File: rtl/dchan_line_mux.sv
module dchan_line_mux
   import dlm_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int LO_DBITS = 1,
   parameter int HI_DBITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_rate,
   input  logic              d_in_b,
   input  logic              modem_mode,
   input  logic [BYTE_W-1:0] tx_b1,
   input  logic [BYTE_W-1:0] tx_b2,
   input  logic [BYTE_W-1:0] tx_d,
   input  logic              tx_hk,
   output logic              line_tx,
   output logic              frame_start,
   input  logic              line_rx,
   output logic [BYTE_W-1:0] rx_b1,
   output logic [BYTE_W-1:0] rx_b2,
   output logic [BYTE_W-1:0] rx_d,
   output logic              rx_hk,
   output logic              rx_done
);

   localparam int CNT_W = $clog2(2*BYTE_W + HI_DBITS + 2);
   localparam int IDX_W = $clog2(BYTE_W);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("dchan_line_mux: BYTE_W must be at least 2");
   end
   if (LO_DBITS < 1 || HI_DBITS < LO_DBITS || HI_DBITS > BYTE_W) begin : g_bad_dbits
      $error("dchan_line_mux: need 1 <= LO_DBITS <= HI_DBITS <= BYTE_W");
   end

   lcfg_t            cfg_in, cfg_q;
   logic [CNT_W-1:0] cnt;
   logic             primed, last, load;
   slot_e            slot;
   logic [IDX_W-1:0] idx;

   assign cfg_in = '{hi_rate: hi_rate, d_in_b: d_in_b, modem: modem_mode};

   dlm_frame_timer #(
      .BYTE_W(BYTE_W), .LO_DBITS(LO_DBITS), .HI_DBITS(HI_DBITS), .CNT_W(CNT_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .cnt(cnt), .cfg_q(cfg_q),
      .primed(primed), .last(last), .load(load)
   );

   dlm_slot_decode #(
      .BYTE_W(BYTE_W), .LO_DBITS(LO_DBITS), .HI_DBITS(HI_DBITS),
      .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_decode (
      .cnt(cnt), .cfg(cfg_q), .slot(slot), .idx(idx)
   );

   dlm_tx_mux #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(load), .primed(primed), .cfg(cfg_q),
      .slot(slot), .idx(idx), .b1_in(tx_b1), .b2_in(tx_b2), .d_in(tx_d),
      .hk_in(tx_hk), .line_bit(line_tx)
   );

   dlm_rx_demux #(
      .BYTE_W(BYTE_W), .LO_DBITS(LO_DBITS), .HI_DBITS(HI_DBITS)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .primed(primed), .last(last), .cfg(cfg_q),
      .slot(slot), .line_bit(line_rx), .rx_b1(rx_b1), .rx_b2(rx_b2),
      .rx_d(rx_d), .rx_hk(rx_hk), .rx_done(rx_done)
   );

   assign frame_start = primed && (cnt == '0);

   assert_start_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> frame_start);

   assert_done_follows_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> rx_done);

   assert_no_start_unprimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> !frame_start && !rx_done);

endmodule

// File: tb/tb_dchan_line_mux.sv
module tb_dchan_line_mux;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hi_rate = 1'b0, d_in_b = 1'b0, modem_mode = 1'b0;
   logic [7:0] tx_b1 = '0, tx_b2 = '0, tx_d = '0;
   logic       tx_hk = 1'b0;
   logic       line_rx = 1'b0;
   logic       line_tx, frame_start, rx_hk, rx_done;
   logic [7:0] rx_b1, rx_b2, rx_d;

   always #(CLK_PERIOD/2) clk = ~clk;

   dchan_line_mux dut (
      .clk(clk), .rst_n(rst_n), .hi_rate(hi_rate), .d_in_b(d_in_b),
      .modem_mode(modem_mode), .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_d(tx_d),
      .tx_hk(tx_hk), .line_tx(line_tx), .frame_start(frame_start),
      .line_rx(line_rx), .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_d(rx_d),
      .rx_hk(rx_hk), .rx_done(rx_done)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;
   bit churn = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // reference model state
   bit    q[$];
   int    fq[$];
   string tq[$];
   int    start_len;
   bit    started;
   bit    m_hi, m_dinb, m_modem;
   logic [7:0] mb1 = 8'hFF, mb2 = 8'hFF;
   logic [1:0] md = 2'b11;
   logic       mhk = 1'b1;
   bit    exp_done;
   logic [7:0] e_b1, e_b2, e_d;
   logic       e_hk;

   task automatic build_frame();
      string tg;
      m_hi    = hi_rate;
      m_dinb  = d_in_b;
      m_modem = modem_mode;
      tg = m_modem ? "R5" : (m_hi ? "R3" : "R2");
      for (int i = 7; i >= 0; i--) begin
         q.push_back((m_dinb && !m_modem) ? tx_d[i] : tx_b1[i]);
         fq.push_back(0);
         tq.push_back((m_dinb && !m_modem) ? "R4" : tg);
      end
      if (m_hi) begin
         for (int i = 7; i >= 0; i--) begin
            q.push_back(tx_b2[i]); fq.push_back(1); tq.push_back(tg);
         end
      end
      if (!m_modem) begin
         if (m_hi) begin
            q.push_back(m_dinb ? 1'b1 : tx_d[1]); fq.push_back(2);
            tq.push_back(m_dinb ? "R4" : tg);
         end
         q.push_back(m_dinb ? 1'b1 : tx_d[0]); fq.push_back(2);
         tq.push_back(m_dinb ? "R4" : tg);
         q.push_back(tx_hk); fq.push_back(3); tq.push_back(tg);
      end
      start_len = q.size();
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); fq.delete(); tq.delete();
         started = 0;
         exp_done = 0;
         mb1 = 8'hFF; mb2 = 8'hFF; md = 2'b11; mhk = 1'b1;
      end else begin
         exp_done = 0;
         if (started) begin
            case (fq[0])
               0: mb1 = {mb1[6:0], line_rx};
               1: mb2 = {mb2[6:0], line_rx};
               2: md  = {md[0], line_rx};
               default: mhk = line_rx;
            endcase
            void'(q.pop_front()); void'(fq.pop_front()); void'(tq.pop_front());
            if (q.size() == 0) begin
               exp_done = 1;
               e_b1 = (m_dinb && !m_modem) ? 8'hFF : mb1;
               e_b2 = m_hi ? mb2 : 8'hFF;
               if (m_modem)     e_d = 8'hFF;
               else if (m_dinb) e_d = mb1;
               else             e_d = m_hi ? {6'h3F, md} : {7'h7F, md[0]};
               e_hk = m_modem ? 1'b1 : mhk;
            end
         end
         if (q.size() == 0) begin
            build_frame();
            started = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && started && !finished) begin
         string t;
         t = churn ? {tq[0], " R7"} : tq[0];
         chk(line_tx == q[0], t, "line_tx", int'(line_tx), int'(q[0]));
         chk(frame_start == (q.size() == start_len), "R6", "frame_start",
             int'(frame_start), int'(q.size() == start_len));
         chk(rx_done == exp_done, "R8", "rx_done", int'(rx_done), int'(exp_done));
         if (exp_done) begin
            chk(rx_b1 == e_b1, "R8 R9", "rx_b1", int'(rx_b1), int'(e_b1));
            chk(rx_b2 == e_b2, "R8 R9", "rx_b2", int'(rx_b2), int'(e_b2));
            chk(rx_d == e_d, "R8 R9", "rx_d", int'(rx_d), int'(e_d));
            chk(rx_hk == e_hk, "R8 R9", "rx_hk", int'(rx_hk), int'(e_hk));
         end
      end
   end

   task automatic run_cycles(input int n, input int every);
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         #1;
         line_rx = 1'($urandom);
         if ((c % every) == 0) begin
            tx_b1 = 8'($urandom); tx_b2 = 8'($urandom);
            tx_d  = 8'($urandom); tx_hk = 1'($urandom);
         end
      end
   endtask

   task automatic idle_check(input string when);
      chk(line_tx == 1'b1, "R1", {when, " line_tx"}, int'(line_tx), 1);
      chk(frame_start == 1'b0, "R1", {when, " frame_start"}, int'(frame_start), 0);
      chk(rx_done == 1'b0, "R1", {when, " rx_done"}, int'(rx_done), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      idle_check("in reset");
      chk(rx_d == 8'hFF, "R1", "rx_d in reset", int'(rx_d), 8'hFF);
      rst_n = 1'b1;
      #1;
      idle_check("before first edge");
      // each setting combination with data changing every few cycles
      for (int m = 0; m < 8; m++) begin
         @(negedge clk);
         #1;
         hi_rate = m[0]; d_in_b = m[1]; modem_mode = m[2];
         run_cycles(240, 7);
      end
      // settings and data move every cycle (R7)
      churn = 1;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         #1;
         hi_rate = 1'($urandom); d_in_b = 1'($urandom); modem_mode = 1'($urandom);
         tx_b1 = 8'($urandom); tx_b2 = 8'($urandom);
         tx_d  = 8'($urandom); tx_hk = 1'($urandom);
         line_rx = 1'($urandom);
      end
      churn = 0;
      // mid-run reset returns to idle (R1)
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      @(negedge clk);
      #1;
      idle_check("after reset reassert");
      rst_n = 1'b1;
      run_cycles(100, 3);
      @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule